// File: doc/BRIEF.md
# Push-Pull PWM Modulator Core

This block is the digital timing heart of a two-phase push-pull switching converter. A free-running counter sets the half-cycle length, and a digital ramp climbs from a nonzero floor once per half cycle. The ramp is compared with the smaller of two reference codes: one from the loop error amplifier and one from a soft-start generator. A third limit is a fixed ceiling that sits below the ramp's peak. While the ramp stays at or below that threshold, the selected output is on. Once the ramp passes it, a turn-off latch holds the output low until the next half cycle starts.

A phase toggle flips at every counter wrap, so the two outputs take turns and are never on together. The last clock of every half cycle is always an off slot. A fault-disable input blanks both outputs at the next clock edge and keeps them off for the rest of that half cycle. A one-clock sync pulse marks the start of each half cycle. The rising edge of an external sync input restarts the half cycle, so several modulators can share one frequency.

The period setting `period_len` is the half-cycle length minus one and must be at least 2. With the default parameters, the ramp floor is 1475, the ramp step is 16 per clock, the ramp saturates at 4095, and the reference ceiling is 3723.

Top module: `pp_pwm_core`

## Requirements
- R1: `q1` and `q2` are never high in the same cycle. In the cycle where `sync_out` is high, both outputs are low (a dead slot at every half-cycle boundary).
- R2: The active phase alternates at every half-cycle start. A half cycle that drives `q1` is followed by one that drives `q2`, and the other way round. Within one half cycle, only one of the two outputs ever goes high.
- R3: The number of high clocks on the active output in a half cycle is N = min(P, floor((T - 1475) / 16) + 1) when T >= 1475, and 0 otherwise. Here P = `period_len` and T is the threshold of R4. On the other output, N clocks go high in the following half cycle.
- R4: The threshold T is the smallest of `ref_err`, `ref_soft` and the ceiling 3723.
- R5: When T is below the ramp floor of 1475, both outputs stay low; T = 1475 gives exactly one high clock per half cycle.
- R6: A high `fault_off` sampled at a clock edge makes both outputs low after that edge. The interrupted half cycle stays off even after `fault_off` drops. The next half cycle delivers its full N on the other phase.
- R7: `sync_out` is a single-clock pulse at the start of each half cycle. Consecutive pulses are `period_len`+1 clocks apart, whatever the reference codes are.
- R8: A rising edge on `sync_in` restarts the half cycle. `sync_out` goes high in the third clock after the edge is first sampled and low in the two clocks before. The restarted half cycle is a full one.
- R9: While `rst_n` is low, `q1`, `q2` and `sync_out` are low. The first half cycle after reset drives `q1`.
- R10: With both references at full scale (4095), the on-time is capped at 141 clocks per half cycle, even when the half cycle is longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_len | input | 16 | Half-cycle length minus one, in clocks (at least 2) |
| ref_err | input | 12 | Error-amplifier reference code, unsigned |
| ref_soft | input | 12 | Soft-start reference code, unsigned |
| fault_off | input | 1 | Fault disable, active high |
| sync_in | input | 1 | External sync; its rising edge restarts the half cycle |
| q1 | output | 1 | Phase 1 drive |
| q2 | output | 1 | Phase 2 drive |
| sync_out | output | 1 | One-clock pulse at each half-cycle start |

## Verification
The bench walks a set of period and reference pairs and counts on-clocks per phase across two half cycles.

- **Threshold edges.** The set includes a reference one code under the ramp floor and one exactly at it. A design with an inverted or off-by-one comparison would give one clock too many or too few.
- **Duty ceiling and dead slot.** It drives full-scale references on a long half cycle to expose a missing ceiling. It uses a very short half cycle to expose a missing dead slot, which would show up as P+1 on-clocks or as an overlap at the boundary.
- **Fault handling.** The fault test drops `fault_off` in the middle of a pulse. A latch that does not hold would let the pulse resume, and a slow blanking path would leave an output high one clock too long.
- **External sync.** The sync test pulses `sync_in` mid-cycle. It catches a wrong synchronizer depth, and a restart that fails to reset the ramp or the phase.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;

  // Phase selected by the half-cycle toggle; the code doubles as the output index.
  typedef enum logic {
    PH_Q1 = 1'b0,
    PH_Q2 = 1'b1
  } phase_e;

  localparam int NUM_PH = 2;

endpackage

// File: rtl/pp_period_timer.sv
module pp_period_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [CNT_W-1:0] period_len,
  input  logic             sync_in,
  output logic             wrap,
  output logic             sync_out
);

  localparam int SYNC_STAGES = 3;

  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [SYNC_STAGES-1:0] sync_sh_q, sync_sh_d;
  logic                   restart;
  logic                   sync_out_q, sync_out_d;

  // Two stages resynchronise the input, the third one finds its rising edge.
  assign restart = sync_sh_q[1] & ~sync_sh_q[2];
  assign wrap    = (cnt_q >= period_len) | restart;

  always_comb begin
    sync_sh_d  = {sync_sh_q[SYNC_STAGES-2:0], sync_in};
    cnt_d      = wrap ? '0 : cnt_q + 1'b1;
    sync_out_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt_q      <= '0;
      sync_sh_q  <= '0;
      sync_out_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      sync_sh_q  <= sync_sh_d;
      sync_out_q <= sync_out_d;
    end
  end

  assign sync_out = sync_out_q;

endmodule

// File: rtl/pp_ramp_gen.sv
module pp_ramp_gen #(
  parameter int CODE_W    = 12,
  parameter int RAMP_MIN  = 1475,
  parameter int RAMP_STEP = 16
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              wrap,
  output logic [CODE_W-1:0] ramp
);

  localparam int               SUM_W = CODE_W + 1;
  localparam logic [SUM_W-1:0] FULL  = SUM_W'((1 << CODE_W) - 1);
  localparam logic [SUM_W-1:0] STEP  = SUM_W'(RAMP_STEP);
  localparam logic [CODE_W-1:0] FLOOR = CODE_W'(RAMP_MIN);

  logic [CODE_W-1:0] ramp_q, ramp_d;
  logic [SUM_W-1:0]  sum;

  assign sum = {1'b0, ramp_q} + STEP;

  // Restart at the floor on a wrap, otherwise climb and stick at full scale.
  always_comb begin
    if (wrap) begin
      ramp_d = FLOOR;
    end else if (sum > FULL) begin
      ramp_d = FULL[CODE_W-1:0];
    end else begin
      ramp_d = sum[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ramp_q <= FLOOR;
    end else begin
      ramp_q <= ramp_d;
    end
  end

  assign ramp = ramp_q;

endmodule

// File: rtl/pp_ref_cmp.sv
module pp_ref_cmp #(
  parameter int CODE_W  = 12,
  parameter int REF_CAP = 3723
) (
  input  logic [CODE_W-1:0] ref_err,
  input  logic [CODE_W-1:0] ref_soft,
  input  logic [CODE_W-1:0] ramp,
  output logic              cut
);

  localparam logic [CODE_W-1:0] CAP = CODE_W'(REF_CAP);

  logic [CODE_W-1:0] low_ref;
  logic [CODE_W-1:0] thr;

  always_comb begin
    low_ref = (ref_err < ref_soft) ? ref_err : ref_soft;
    thr     = (low_ref < CAP) ? low_ref : CAP;
    cut     = ramp > thr;
  end

endmodule

// File: rtl/pp_pulse_steer.sv
module pp_pulse_steer
  import pp_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              wrap,
  input  logic              cut,
  input  logic              fault_off,
  output logic [NUM_PH-1:0] q
);

  phase_e            sel_q, sel_d;
  logic              arm_q, arm_d;
  logic              live;
  logic [NUM_PH-1:0] q_q, q_d;

  // The wrap cycle itself is always dead; a fault or a ramp crossing clears the latch.
  assign live = arm_q & ~cut & ~wrap & ~fault_off;

  always_comb begin
    sel_d = wrap ? phase_e'(~sel_q) : sel_q;
    arm_d = wrap ? ~fault_off : live;
  end

  for (genvar i = 0; i < NUM_PH; i++) begin : g_phase
    assign q_d[i] = live & (sel_q == phase_e'(1'(i)));
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_q <= PH_Q1;
      arm_q <= 1'b1;
      q_q   <= '0;
    end else begin
      sel_q <= sel_d;
      arm_q <= arm_d;
      q_q   <= q_d;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/pp_pwm_core.sv
module pp_pwm_core
  import pp_pwm_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int CNT_W     = 16,
  parameter int RAMP_MIN  = 1475,
  parameter int RAMP_STEP = 16,
  parameter int REF_CAP   = 3723
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  period_len,
  input  logic [CODE_W-1:0] ref_err,
  input  logic [CODE_W-1:0] ref_soft,
  input  logic              fault_off,
  input  logic              sync_in,
  output logic              q1,
  output logic              q2,
  output logic              sync_out
);

  logic [1:0]        rst_sh_q;
  logic              rst_q_n;
  logic              wrap;
  logic              cut;
  logic [CODE_W-1:0] ramp;
  logic [NUM_PH-1:0] q;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q <= '0;
    end else begin
      rst_sh_q <= {rst_sh_q[0], 1'b1};
    end
  end

  assign rst_q_n = rst_sh_q[1];

  pp_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .period_len (period_len),
    .sync_in    (sync_in),
    .wrap       (wrap),
    .sync_out   (sync_out)
  );

  pp_ramp_gen #(
    .CODE_W    (CODE_W),
    .RAMP_MIN  (RAMP_MIN),
    .RAMP_STEP (RAMP_STEP)
  ) u_ramp (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .wrap    (wrap),
    .ramp    (ramp)
  );

  pp_ref_cmp #(
    .CODE_W  (CODE_W),
    .REF_CAP (REF_CAP)
  ) u_cmp (
    .ref_err  (ref_err),
    .ref_soft (ref_soft),
    .ramp     (ramp),
    .cut      (cut)
  );

  pp_pulse_steer u_steer (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .wrap      (wrap),
    .cut       (cut),
    .fault_off (fault_off),
    .q         (q)
  );

  assign q1 = q[PH_Q1];
  assign q2 = q[PH_Q2];

endmodule

// File: rtl/pp_pwm_core_chk.sv
module pp_pwm_core_chk #(
  parameter int CODE_W   = 12,
  parameter int RAMP_MIN = 1475
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_q_n,
  input logic [CODE_W-1:0] ref_err,
  input logic [CODE_W-1:0] ref_soft,
  input logic              fault_off,
  input logic              sync_in,
  input logic              q1,
  input logic              q2,
  input logic              sync_out
);

  localparam logic [CODE_W-1:0] FLOOR = CODE_W'(RAMP_MIN);

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(q1 && q2));

  a_r1_dead_slot: assert property (@(posedge clk) disable iff (!rst_q_n)
    sync_out |-> (!q1 && !q2));

  a_r5_below_floor: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((ref_err < FLOOR) || (ref_soft < FLOOR)) |=> (!q1 && !q2));

  a_r6_fault_off: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault_off |=> (!q1 && !q2));

  a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_q_n)
    sync_out |=> !sync_out);

  a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(sync_in) |-> ##3 sync_out);

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!q1 && !q2 && !sync_out));

endmodule

bind pp_pwm_core pp_pwm_core_chk #(
  .CODE_W   (CODE_W),
  .RAMP_MIN (RAMP_MIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q_n   (rst_q_n),
  .ref_err   (ref_err),
  .ref_soft  (ref_soft),
  .fault_off (fault_off),
  .sync_in   (sync_in),
  .q1        (q1),
  .q2        (q2),
  .sync_out  (sync_out)
);

// File: tb/pp_pwm_core_test.sv
module pp_pwm_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] period_len = 16'd199;
  logic [11:0] ref_err = 12'd3000;
  logic [11:0] ref_soft = 12'd4095;
  logic        fault_off = 1'b0;
  logic        sync_in = 1'b0;
  logic        q1, q2, sync_out;

  int total = 0;
  int bad = 0;
  int overlap_seen = 0;
  int dead_slot_viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pp_pwm_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_len (period_len),
    .ref_err    (ref_err),
    .ref_soft   (ref_soft),
    .fault_off  (fault_off),
    .sync_in    (sync_in),
    .q1         (q1),
    .q2         (q2),
    .sync_out   (sync_out)
  );

  // {period_len, ref_err, ref_soft, expected on-clocks per half cycle}
  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{199, 3000, 4095,  96},   // R3 error reference lower
    '{199, 4095, 2000,  33},   // R4 soft-start reference lower
    '{199, 4095, 4095, 141},   // R10 ceiling
    '{199, 1474, 4095,   0},   // R5 one under the floor
    '{199, 1475, 4095,   1},   // R5 at the floor
    '{199, 4095, 1491,   2},   // R3 second ramp step
    '{ 19, 3000, 3000,  19},   // R1 dead slot limits a short half cycle
    '{ 63, 2000, 2500,  33},   // R4 mixed references
    '{149, 3800, 4000, 141}    // R4 both above the ceiling
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sync();
    @(negedge clk);
    while (!sync_out) @(negedge clk);
  endtask

  // Starting on a sync negedge: count each phase over two half cycles.
  task automatic measure(input int p, input int n, input string tag);
    int h1q1 = 0, h1q2 = 0, h2q1 = 0, h2q2 = 0;
    bit sync_ok = 1'b1;
    for (int idx = 0; idx < 2 * (p + 1); idx++) begin
      if (idx > 0) @(negedge clk);
      if (idx <= p) begin h1q1 += int'(q1); h1q2 += int'(q2); end
      else begin h2q1 += int'(q1); h2q2 += int'(q2); end
      if (idx == p + 1) begin if (!sync_out) sync_ok = 1'b0; end
      else if (idx > 0 && sync_out) sync_ok = 1'b0;
    end
    check(h1q1 + h1q2 == n && h2q1 + h2q2 == n, {"R3 on-time ", tag}, h1q1 + h1q2 + h2q1 + h2q2, 2 * n);
    check((h1q1 == 0 || h1q2 == 0) && (h1q1 == h2q2) && (h1q2 == h2q1),
          {"R2 alternation ", tag}, h1q1 * 1000 + h2q2, h2q2 * 1000 + h1q1);
    check(sync_ok, {"R7 sync spacing ", tag}, int'(sync_ok), 1);
  endtask

  always @(negedge clk) begin
    if (rst_n && q1 && q2) overlap_seen++;
    if (rst_n && sync_out && (q1 || q2)) dead_slot_viol++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    // R9: quiet during reset
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!q1 && !q2 && !sync_out, "R9 reset quiet", int'({q1, q2, sync_out}), 0);
    end
    rst_n = 1'b1;
    begin
      int guard = 0;
      @(negedge clk);
      while (!q1 && !q2 && guard < 500) begin @(negedge clk); guard++; end
      check(q1 && !q2, "R9 first phase is q1", int'({q1, q2}), 2);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      period_len = 16'(VEC[v][0]);
      ref_err    = 12'(VEC[v][1]);
      ref_soft   = 12'(VEC[v][2]);
      wait_sync(); wait_sync(); wait_sync();
      measure(VEC[v][0], VEC[v][3], $sformatf("vec%0d", v));
    end

    // R6: fault in the middle of a pulse
    @(negedge clk);
    period_len = 16'd199; ref_err = 12'd3000; ref_soft = 12'd4095;
    wait_sync(); wait_sync();
    begin
      bit was_q1;
      int leak = 0, same = 0, other = 0;
      repeat (20) @(negedge clk);
      was_q1 = q1;
      check(q1 || q2, "R6 pulse active before fault", int'({q1, q2}), 1);
      fault_off = 1'b1;
      @(negedge clk);
      check(!q1 && !q2, "R6 outputs off one clock after fault", int'({q1, q2}), 0);
      repeat (4) @(negedge clk);
      fault_off = 1'b0;
      @(negedge clk);
      while (!sync_out) begin leak += int'(q1) + int'(q2); @(negedge clk); end
      check(leak == 0, "R6 half cycle stays off", leak, 0);
      for (int idx = 0; idx <= 199; idx++) begin
        if (idx > 0) @(negedge clk);
        if (was_q1) begin other += int'(q2); same += int'(q1); end
        else begin other += int'(q1); same += int'(q2); end
      end
      check(other == 96 && same == 0, "R6 next half full on other phase", other, 96);
    end

    // R8: external sync restart
    wait_sync();
    repeat (50) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    check(!sync_out, "R8 no sync at +1", int'(sync_out), 0);
    @(negedge clk);
    check(!sync_out, "R8 no sync at +2", int'(sync_out), 0);
    @(negedge clk);
    check(sync_out, "R8 sync at +3", int'(sync_out), 1);
    sync_in = 1'b0;
    begin
      int on = 0;
      bit next_ok;
      for (int idx = 0; idx <= 199; idx++) begin
        if (idx > 0) @(negedge clk);
        on += int'(q1) + int'(q2);
      end
      @(negedge clk);
      next_ok = sync_out;
      check(on == 96, "R8 restarted half cycle is full", on, 96);
      check(next_ok, "R8 R7 next sync after full period", int'(next_ok), 1);
    end

    // R1: continuous monitors
    check(overlap_seen == 0, "R1 outputs never overlap", overlap_seen, 0);
    check(dead_slot_viol == 0, "R1 dead slot at sync", dead_slot_viol, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule